// File: doc/BRIEF.md
# Target-Cycle Step Controller

This block lets a latency-insensitive leaf unit advance one target clock cycle at a time, while each target cycle may take any number of host clock cycles. It sits between the unit and a set of input and output channel FIFOs. Every input FIFO must hold one token for the current target cycle, and every output FIFO must have room for one token. The token can be a real message or an idle marker. When both hold, the controller raises a one-cycle start strobe to the unit and then waits for the unit's done strobe.

In the host cycle where done is seen, the controller pops one token from every input FIFO and pushes one token into every output FIFO. It also advances a target-cycle counter. A target cycle in which the unit carries no real message still counts, because idle tokens are consumed and produced like any other.

A step-enable input holds target time, which makes single stepping or slowed execution possible. While it is low, no new target cycle begins, but a cycle already started runs to completion.

Top module: `tcyc_step_ctl`

## Requirements
- R1: After reset, `unit_start`, `busy`, every bit of `in_pop` and every bit of `out_push` are 0, and `tcycle` is 0.
- R2: `unit_start` is 1 in a host cycle exactly when `busy` is 0, all bits of `in_valid` are 1, all bits of `out_ready` are 1 and `step_en` is 1. In that same cycle the start signal is combinational from those inputs.
- R3: `unit_start` lasts one host cycle. No further start occurs until the running target cycle has been committed.
- R4: While `busy` is 1 and `unit_done` is 1, all bits of `in_pop` and all bits of `out_push` are 1 in that same host cycle, and `busy` is 0 in the next cycle. In every other cycle, all of these pop and push bits are 0.
- R5: `tcycle` increases by one, modulo 2^CNT_W, on the clock edge that ends a commit cycle. Otherwise it holds its value.
- R6: `unit_done` while `busy` is 0 has no effect: no pop, no push, no counter change, and `busy` stays 0.
- R7: `step_en` low does not stop a target cycle that is already running: done is still committed.
- R8: `busy` becomes 1 in the host cycle after a start and stays 1 until the commit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Allows a new target cycle to begin |
| in_valid | input | N_IN | Input FIFO holds a token, one bit per input |
| in_pop | output | N_IN | Dequeue strobe, one bit per input |
| out_ready | input | N_OUT | Output FIFO has room, one bit per output |
| out_push | output | N_OUT | Enqueue strobe, one bit per output |
| unit_start | output | 1 | Begin-target-cycle pulse to the unit |
| unit_done | input | 1 | Unit finished the current target cycle |
| busy | output | 1 | A target cycle is in progress |
| tcycle | output | CNT_W | Completed target-cycle count |

## Verification
The bench targets these cases and the faults each one exposes:
- A stray done while idle. A design that honoured it would pop FIFOs that hold no claimed token and would skew the counter.
- A single missing input token or a single full output FIFO. A controller that reduced the conditions with OR instead of AND would start too early.
- Step-enable dropping mid-cycle. A controller that aborted would hang the unit or lose the commit.
- Done arriving in the first busy cycle, and counter wrap-around. These expose off-by-one delays and width errors.

// File: rtl/tcyc_step_ctl.sv
module tcyc_step_ctl #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [N_IN-1:0]  in_valid,
  output logic [N_IN-1:0]  in_pop,
  input  logic [N_OUT-1:0] out_ready,
  output logic [N_OUT-1:0] out_push,
  output logic             unit_start,
  input  logic             unit_done,
  output logic             busy,
  output logic [CNT_W-1:0] tcycle
);
  logic commit;

  assign unit_start = !busy && (&in_valid) && (&out_ready) && step_en;
  assign commit     = busy && unit_done;
  assign in_pop     = {N_IN{commit}};
  assign out_push   = {N_OUT{commit}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tcycle <= '0;
    end else begin
      if (unit_start)  busy <= 1'b1;
      else if (commit) busy <= 1'b0;
      if (commit) tcycle <= tcycle + 1'b1;
    end
  end
endmodule

module tcyc_step_ctl_chk #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 2,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input logic [N_IN-1:0]  in_valid,
  input logic [N_IN-1:0]  in_pop,
  input logic [N_OUT-1:0] out_ready,
  input logic [N_OUT-1:0] out_push,
  input logic             unit_start,
  input logic             unit_done,
  input logic             busy,
  input logic [CNT_W-1:0] tcycle
);
  AST_START_COND: assert property (@(posedge clk) disable iff (!rst_n)
    unit_start |-> (&in_valid && &out_ready && step_en && !busy)); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    unit_start |=> !unit_start); // R3
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    unit_start |=> busy); // R8
  AST_COMMIT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_pop || |out_push) |-> (&in_pop && &out_push && busy && unit_done)); // R4
  AST_COMMIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_pop) |=> !busy); // R4
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && unit_done) |-> (in_pop == '0 && out_push == '0)); // R6
  AST_STEP_HOLD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && unit_done && !step_en) |-> &in_pop); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_pop) |=> tcycle == CNT_W'($past(tcycle) + 1'b1)); // R5
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(|in_pop) |=> $stable(tcycle)); // R5
endmodule

bind tcyc_step_ctl tcyc_step_ctl_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_tcyc_step_ctl.sv
module test_tcyc_step_ctl;
  localparam int N_IN = 3, N_OUT = 2, CNT_W = 8;
  logic clk = 0, rst_n = 0, step_en = 0, unit_done = 0;
  logic [N_IN-1:0] in_valid = '0, in_pop;
  logic [N_OUT-1:0] out_ready = '0, out_push;
  logic unit_start, busy;
  logic [CNT_W-1:0] tcycle;
  int n_chk = 0, n_fail = 0;
  bit m_busy = 0;
  logic [CNT_W-1:0] m_cnt = '0;
  int rem = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  tcyc_step_ctl #(.N_IN(N_IN), .N_OUT(N_OUT), .CNT_W(CNT_W)) i_tcyc_step_ctl (.*);

  function automatic bit exp_start(bit b, logic [N_IN-1:0] v, logic [N_OUT-1:0] r, bit s);
    return !b && (&v) && (&r) && s;
  endfunction

  function automatic bit exp_commit(bit b, bit d);
    return b && d;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    bit c;
    c = exp_commit(m_busy, unit_done);
    chk({tag, " R2 start"}, unit_start, exp_start(m_busy, in_valid, out_ready, step_en));
    chk({tag, " R4 in_pop"}, in_pop, c ? {N_IN{1'b1}} : '0);
    chk({tag, " R4 out_push"}, out_push, c ? {N_OUT{1'b1}} : '0);
    chk({tag, " R8 busy"}, busy, m_busy);
    chk({tag, " R5 tcycle"}, tcycle, m_cnt);
  endtask

  task automatic advance();
    bit s, c;
    s = exp_start(m_busy, in_valid, out_ready, step_en);
    c = exp_commit(m_busy, unit_done);
    if (s) begin m_busy = 1; rem = $urandom_range(0, 4); end
    else if (c) begin m_busy = 0; m_cnt = m_cnt + 1'b1; end
    else if (m_busy && rem > 0) rem--;
    @(posedge clk);
  endtask

  task automatic drive(bit s, logic [N_IN-1:0] v, logic [N_OUT-1:0] r, bit d);
    @(negedge clk);
    step_en = s; in_valid = v; out_ready = r; unit_done = d;
    #1;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 150000 && !done_flag) begin @(posedge clk); cyc++; end
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 start", unit_start, 0);
    chk("R1 busy", busy, 0);
    chk("R1 tcycle", tcycle, 0);
    chk("R1 pop", in_pop, 0);
    chk("R1 push", out_push, 0);
    @(negedge clk); rst_n = 1;

    drive(1, '1, '1, 1); check_all("R6 idle-done-with-start"); advance();
    drive(1, '1, '1, 0); check_all("R3 no restart while busy"); advance();
    drive(1, '1, '1, 1); check_all("R4 commit"); advance();
    drive(0, '1, '1, 1); check_all("R6 stray done idle"); advance();
    drive(1, 3'b101, '1, 0); check_all("R2 one input empty"); advance();
    drive(1, '1, 2'b10, 0); check_all("R2 one output full"); advance();
    drive(1, '1, '1, 0); check_all("R2 start"); advance();
    drive(0, '1, '1, 0); check_all("R7 step low busy"); advance();
    drive(0, '1, '1, 1); check_all("R7 commit with step low"); advance();
    drive(0, '1, '1, 0); check_all("R7 no new start"); advance();

    for (int i = 0; i < 6000; i++) begin
      bit s, d;
      logic [N_IN-1:0] v;
      logic [N_OUT-1:0] r;
      s = ($urandom_range(0, 9) != 0);
      v = ($urandom_range(0, 3) != 0) ? '1 : N_IN'($urandom);
      r = ($urandom_range(0, 3) != 0) ? '1 : N_OUT'($urandom);
      if (m_busy) d = (rem == 0);
      else d = ($urandom_range(0, 3) == 0);
      drive(s, v, r, d);
      check_all("rand R2 R4 R5 R6 R7 R8");
      advance();
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule